// File: doc/BRIEF.md
# Configuration Port Bridge

This block sits between a host I/O port bus and a configuration-space fabric. Software first writes a 32-bit address word to the address port. That word holds an enable bit, a bus number, a device/function number and a dword register index. Software then reads or writes the four-byte data window. Each data-window access that arrives while the enable bit is set becomes one downstream configuration request. The request carries the latched routing fields, byte enables for the lanes touched, and write data shifted onto those lanes. The target's read data comes back shifted down to bit 0.

The register index reaches 4096 bytes per function. The upper four index bits live in address-word bits 27:24, next to the classic 256-byte offset in bits 7:2. The host holds its access until the bridge pulses `io_done`. The downstream request uses a valid/ready handshake. Host accesses to any other port, and byte or word accesses to the address port, complete at once and have no effect.

Top module: `cfg_port_bridge`

## Requirements
- R1: A dword write (io_size 2 or 3) to port ADDR_PORT loads the address word. Bits 30:28 and 1:0 are forced to zero. A dword read of that port returns the stored word.
- R2: When address-word bit 31 is clear, a data-window read returns 32'hFFFFFFFF and a data-window write is dropped; neither raises cfg_valid.
- R3: Requests carry cfg_bus = word[23:16] and cfg_devfn = word[15:8]. cfg_dword is {word[27:24], word[7:2]}, a 10-bit dword index.
- R4: A byte access (io_size 0) uses lane io_addr[1:0], so cfg_be has the single bit 1 << io_addr[1:0].
- R5: A word access (io_size 1) uses only io_addr[1]: cfg_be is 4'b0011 when that bit is 0 and 4'b1100 when it is 1. io_addr[0] is ignored.
- R6: A dword access uses lane 0 with cfg_be = 4'b1111 for any io_addr[1:0] in the window.
- R7: On a write, cfg_wdata is io_wdata shifted left by 8 times the lane number.
- R8: Read data is cfg_rdata shifted right by 8 times the lane number. Bytes above the access width are returned as zero.
- R9: cfg_valid, cfg_write, cfg_be and cfg_wdata hold steady until cfg_ready. io_done pulses for one cycle, in the cycle after the handshake. A local access (no request) pulses io_done in the cycle after the access is accepted.
- R10: An access to a port outside ADDR_PORT and the data window, or a byte or word access to ADDR_PORT, leaves the address word unchanged, raises no request, and reads 32'hFFFFFFFF.
- R11: After reset the address word is zero, and cfg_valid and io_done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_req | input | 1 | Host access pending; held until io_done |
| io_write | input | 1 | 1 = host write, 0 = host read |
| io_addr | input | IO_AW | Host port address |
| io_size | input | 2 | 0 byte, 1 word, 2 or 3 dword |
| io_wdata | input | 32 | Host write data, right-aligned |
| io_rdata | output | 32 | Host read data, valid with io_done |
| io_done | output | 1 | One-cycle access completion |
| cfg_valid | output | 1 | Downstream request valid |
| cfg_ready | input | 1 | Downstream request accepted and completed |
| cfg_write | output | 1 | Downstream request is a write |
| cfg_bus | output | 8 | Bus number |
| cfg_devfn | output | 8 | Device/function number |
| cfg_dword | output | 10 | Dword register index (4 KiB space) |
| cfg_be | output | 4 | Byte enables |
| cfg_wdata | output | 32 | Lane-placed write data |
| cfg_rdata | input | 32 | Target read data, sampled with cfg_ready |

## Verification
The bench builds the bridge with its default parameters: a 16-bit port address, the address port at 0xCF8 and the data window at 0xCFC. The full 16-bit compare lets an unrelated port such as 0x0080 be reached as a miss. All four window addresses exercise every lane, including a word access at an odd address. Address words with index bits 27:24 all set drive the 10-bit dword index to its top value, and a delayed ready exercises the hold of the request.

// File: rtl/cfgb_pkg.sv
// Shared constants and types for the configuration port bridge.
// Assumes a 32-bit data path split into four byte lanes.
package cfgb_pkg;
    localparam int DW    = 32;
    localparam int LANES = DW / 8;
    localparam int LW    = $clog2(LANES);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_DONE = 2'd2
    } bridge_state_t;
endpackage

// File: rtl/cfgb_addr_latch.sv
// Address word register of the bridge. It stores the enable bit, the bus,
// the device/function and the extended register index, and it splits the
// word into routing fields. It assumes that wr_en is only raised for a dword
// write to the address port while the bridge is idle.
module cfgb_addr_latch
    import cfgb_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_word,
    output logic [DW-1:0] word_q,
    output logic          enable,
    output logic [7:0]    bus,
    output logic [7:0]    devfn,
    output logic [9:0]    dword_idx
);
    localparam logic [DW-1:0] KEEP_MASK = 32'h8FFF_FFFC;

    // Load the writable bits of the address word; reserved bits stay zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            word_q <= '0;
        else if (wr_en)
            word_q <= wr_word & KEEP_MASK;
    end

    // Split the stored word into the routing fields.
    always_comb begin
        enable    = word_q[31];
        bus       = word_q[23:16];
        devfn     = word_q[15:8];
        dword_idx = {word_q[27:24], word_q[7:2]};
    end

    // R1
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_q[30:28] == 3'b000) && (word_q[1:0] == 2'b00));
endmodule

// File: rtl/cfgb_lane_steer.sv
// Byte-lane steering for data-window accesses. From the access size and the
// low port bits it picks the lane, forms the byte enables, places the write
// data on its lanes and brings the read data down to bit 0. It is purely
// combinational and assumes that the inputs stay stable for the whole access.
module cfgb_lane_steer
    import cfgb_pkg::*;
(
    input  logic [1:0]       size,
    input  logic [LW-1:0]    port_lo,
    input  logic [DW-1:0]    wdata_in,
    input  logic [DW-1:0]    rdata_in,
    output logic [LANES-1:0] be,
    output logic [DW-1:0]    wdata_out,
    output logic [DW-1:0]    rdata_out
);
    logic [LW-1:0]    lane;
    logic [LANES-1:0] width_mask;
    logic [DW-1:0]    rd_shifted;

    // Choose the lane and the width mask from the access size.
    always_comb begin
        case (size)
            2'd0: begin
                lane       = port_lo;
                width_mask = 4'b0001;
            end
            2'd1: begin
                lane       = {port_lo[1], 1'b0};
                width_mask = 4'b0011;
            end
            default: begin
                lane       = '0;
                width_mask = 4'b1111;
            end
        endcase
    end

    // Shift the enables and the data by whole lanes.
    always_comb begin
        be         = width_mask << lane;
        wdata_out  = wdata_in << {lane, 3'b000};
        rd_shifted = rdata_in >> {lane, 3'b000};
    end

    // Zero the read bytes that lie above the access width.
    for (genvar g = 0; g < LANES; g++) begin : g_rd_lane
        assign rdata_out[8*g +: 8] = width_mask[g] ? rd_shifted[8*g +: 8] : 8'h00;
    end
endmodule

// File: rtl/cfg_port_bridge.sv
// Top level of the configuration port bridge. It decodes host port accesses,
// updates the address word, and turns data-window accesses into one
// downstream valid/ready request each. The host must hold io_req, io_addr,
// io_size, io_write and io_wdata until io_done, and drop io_req in the cycle
// after io_done. cfg_rdata must be valid in the cycle where cfg_ready is high.
module cfg_port_bridge
    import cfgb_pkg::*;
#(
    parameter int               IO_AW     = 16,
    parameter logic [IO_AW-1:0] ADDR_PORT = 16'hCF8,
    parameter logic [IO_AW-1:0] DATA_PORT = 16'hCFC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             io_req,
    input  logic             io_write,
    input  logic [IO_AW-1:0] io_addr,
    input  logic [1:0]       io_size,
    input  logic [DW-1:0]    io_wdata,
    output logic [DW-1:0]    io_rdata,
    output logic             io_done,
    output logic             cfg_valid,
    input  logic             cfg_ready,
    output logic             cfg_write,
    output logic [7:0]       cfg_bus,
    output logic [7:0]       cfg_devfn,
    output logic [9:0]       cfg_dword,
    output logic [LANES-1:0] cfg_be,
    output logic [DW-1:0]    cfg_wdata,
    input  logic [DW-1:0]    cfg_rdata
);
    localparam logic [DW-1:0] ALL_ONES = '1;

    bridge_state_t    state;
    logic             hit_addr;
    logic             hit_data;
    logic             latch_wr;
    logic             latch_en;
    logic [DW-1:0]    latch_word;
    logic [LANES-1:0] st_be;
    logic [DW-1:0]    st_wdata;
    logic [DW-1:0]    st_rdata;

    // Decode the host port: a dword address-port access, or the data window.
    always_comb begin
        hit_addr = (io_addr == ADDR_PORT) && io_size[1];
        hit_data = (io_addr[IO_AW-1:LW] == DATA_PORT[IO_AW-1:LW]);
        latch_wr = (state == ST_IDLE) && io_req && hit_addr && io_write;
    end

    cfgb_addr_latch u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (latch_wr),
        .wr_word   (io_wdata),
        .word_q    (latch_word),
        .enable    (latch_en),
        .bus       (cfg_bus),
        .devfn     (cfg_devfn),
        .dword_idx (cfg_dword)
    );

    cfgb_lane_steer u_steer (
        .size      (io_size),
        .port_lo   (io_addr[LW-1:0]),
        .wdata_in  (io_wdata),
        .rdata_in  (cfg_rdata),
        .be        (st_be),
        .wdata_out (st_wdata),
        .rdata_out (st_rdata)
    );

    // Sequence each host access: local completion or one downstream request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cfg_valid <= 1'b0;
            cfg_write <= 1'b0;
            cfg_be    <= '0;
            cfg_wdata <= '0;
            io_rdata  <= '0;
        end else begin
            case (state)
                ST_IDLE: if (io_req) begin
                    if (hit_data && latch_en) begin
                        cfg_valid <= 1'b1;
                        cfg_write <= io_write;
                        cfg_be    <= st_be;
                        cfg_wdata <= io_write ? st_wdata : '0;
                        state     <= ST_REQ;
                    end else begin
                        io_rdata  <= (hit_addr && !io_write) ? latch_word : ALL_ONES;
                        state     <= ST_DONE;
                    end
                end
                ST_REQ: if (cfg_ready) begin
                    cfg_valid <= 1'b0;
                    io_rdata  <= cfg_write ? ALL_ONES : st_rdata;
                    state     <= ST_DONE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Completion is signalled for the single cycle spent in the done state.
    assign io_done = (state == ST_DONE);

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid && !cfg_ready |=> cfg_valid && $stable(cfg_be)
                                    && $stable(cfg_wdata) && $stable(cfg_write));
    // R9
    done_after_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid && cfg_ready |=> io_done && !cfg_valid);
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_done |=> !io_done);
    // R2
    req_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> latch_en);
    // R4
    be_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> ($countones(cfg_be) == 1 || cfg_be == 4'b0011
                       || cfg_be == 4'b1100 || cfg_be == 4'b1111));
endmodule

// File: tb/tb_cfg_port_bridge.sv
module tb_cfg_port_bridge;
    localparam int NV = 11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_req = 1'b0;
    logic        io_write = 1'b0;
    logic [15:0] io_addr = '0;
    logic [1:0]  io_size = '0;
    logic [31:0] io_wdata = '0;
    logic [31:0] io_rdata;
    logic        io_done;
    logic        cfg_valid;
    logic        cfg_ready = 1'b0;
    logic        cfg_write;
    logic [7:0]  cfg_bus;
    logic [7:0]  cfg_devfn;
    logic [9:0]  cfg_dword;
    logic [3:0]  cfg_be;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata = '0;

    int checks = 0;
    int errors = 0;

    // captured results of the last access
    logic [31:0] r_rdata, r_wdata;
    logic        r_req, r_write;
    logic [3:0]  r_be;
    logic [7:0]  r_bus, r_devfn;
    logic [9:0]  r_dword;
    int          r_cycles;

    always #4 clk = ~clk;

    cfg_port_bridge dut (
        .clk(clk), .rst_n(rst_n), .io_req(io_req), .io_write(io_write),
        .io_addr(io_addr), .io_size(io_size), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .io_done(io_done), .cfg_valid(cfg_valid),
        .cfg_ready(cfg_ready), .cfg_write(cfg_write), .cfg_bus(cfg_bus),
        .cfg_devfn(cfg_devfn), .cfg_dword(cfg_dword), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
    );

    // table: address word, write flag, port, size, host wdata, target rdata,
    // expected host rdata, request expected, expected be, expected cfg_wdata
    localparam logic [31:0] V_LATCH [NV] = '{32'h8012_3404, 32'h8012_3404, 32'h8012_3404,
        32'h8012_3404, 32'h8012_3404, 32'h8012_3404, 32'h8F00_0AFC, 32'h0012_3404,
        32'h0012_3404, 32'h8012_3404, 32'h8012_3404};
    localparam logic        V_WR    [NV] = '{0, 0, 0, 1, 1, 1, 0, 0, 1, 0, 1};
    localparam logic [15:0] V_PORT  [NV] = '{16'hCFD, 16'hCFE, 16'hCFC, 16'hCFF, 16'hCFC,
        16'hCFC, 16'hCFF, 16'hCFC, 16'hCFD, 16'hCFD, 16'hCFE};
    localparam logic [1:0]  V_SIZE  [NV] = '{0, 1, 2, 0, 1, 2, 0, 2, 0, 1, 1};
    localparam logic [31:0] V_WDATA [NV] = '{0, 0, 0, 32'h0000_00AB, 32'h0000_BEEF,
        32'hDEAD_BEEF, 0, 0, 32'h0000_0055, 0, 32'h0000_CAFE};
    localparam logic [31:0] V_TGT   [NV] = '{32'h4433_2211, 32'h4433_2211, 32'h4433_2211,
        0, 0, 0, 32'h1122_3344, 32'h4433_2211, 0, 32'h4433_2211, 0};
    localparam logic [31:0] V_EXPRD [NV] = '{32'h0000_0022, 32'h0000_4433, 32'h4433_2211,
        0, 0, 0, 32'h0000_0011, 32'hFFFF_FFFF, 0, 32'h0000_2211, 0};
    localparam logic        V_REQ   [NV] = '{1, 1, 1, 1, 1, 1, 1, 0, 0, 1, 1};
    localparam logic [3:0]  V_BE    [NV] = '{4'b0010, 4'b1100, 4'b1111, 4'b1000, 4'b0011,
        4'b1111, 4'b1000, 0, 0, 4'b0011, 4'b1100};
    localparam logic [31:0] V_EXPWD [NV] = '{0, 0, 0, 32'hAB00_0000, 32'h0000_BEEF,
        32'hDEAD_BEEF, 0, 0, 0, 0, 32'hCAFE_0000};

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Run one host access, acting as the target with a given ready delay.
    task automatic access(input logic wr, input logic [15:0] addr, input logic [1:0] sz,
                          input logic [31:0] wd, input logic [31:0] tgt, input int wait_cyc);
        int waited = 0;
        bit seen = 0;
        r_req = 0; r_cycles = 0;
        @(negedge clk);
        io_req = 1; io_write = wr; io_addr = addr; io_size = sz; io_wdata = wd;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            r_cycles++;
            if (io_done) break;
            if (cfg_valid && !cfg_ready) begin
                if (!seen) begin
                    seen = 1; r_req = 1; r_write = cfg_write; r_be = cfg_be;
                    r_wdata = cfg_wdata; r_bus = cfg_bus; r_devfn = cfg_devfn;
                    r_dword = cfg_dword;
                end
                if (waited == wait_cyc) begin
                    cfg_ready = 1; cfg_rdata = tgt;
                end else waited++;
            end
        end
        r_rdata = io_rdata;
        io_req = 0; cfg_ready = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        chk(!cfg_valid, "R11 cfg_valid", {31'd0, cfg_valid}, 0);
        chk(!io_done, "R11 io_done", {31'd0, io_done}, 0);
        access(0, 16'hCF8, 2, 0, 0, 0);
        chk(r_rdata == 0, "R11 address word", r_rdata, 0);

        // R1 reserved bits read back as zero
        access(1, 16'hCF8, 2, 32'hFFFF_FFFF, 0, 0);
        access(0, 16'hCF8, 2, 0, 0, 0);
        chk(r_rdata == 32'h8FFF_FFFC, "R1 readback", r_rdata, 32'h8FFF_FFFC);

        // R10 byte write to the address port is ignored
        access(1, 16'hCF8, 0, 32'h0000_0000, 0, 0);
        access(0, 16'hCF8, 2, 0, 0, 0);
        chk(r_rdata == 32'h8FFF_FFFC, "R10 sub-dword address write", r_rdata, 32'h8FFF_FFFC);
        // R10 unrelated port
        access(0, 16'h0080, 2, 0, 32'h1234_5678, 0);
        chk(r_rdata == 32'hFFFF_FFFF, "R10 miss read", r_rdata, 32'hFFFF_FFFF);
        chk(!r_req, "R10 miss request", {31'd0, r_req}, 0);

        // table walk: R2 R3 R4 R5 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            access(1, 16'hCF8, 2, V_LATCH[i], 0, 0);
            access(V_WR[i], V_PORT[i], V_SIZE[i], V_WDATA[i], V_TGT[i], 0);
            chk(r_req == V_REQ[i], "R2 request raised", {31'd0, r_req}, {31'd0, V_REQ[i]});
            if (!V_WR[i])
                chk(r_rdata == V_EXPRD[i], "R8 read data", r_rdata, V_EXPRD[i]);
            if (V_REQ[i] && r_req) begin
                chk(r_be == V_BE[i], "R4 byte enables", {28'd0, r_be}, {28'd0, V_BE[i]});
                chk(r_write == V_WR[i], "R7 write flag", {31'd0, r_write}, {31'd0, V_WR[i]});
                chk(r_bus == V_LATCH[i][23:16], "R3 bus", {24'd0, r_bus},
                    {24'd0, V_LATCH[i][23:16]});
                chk(r_devfn == V_LATCH[i][15:8], "R3 devfn", {24'd0, r_devfn},
                    {24'd0, V_LATCH[i][15:8]});
                chk(r_dword == {V_LATCH[i][27:24], V_LATCH[i][7:2]}, "R3 dword index",
                    {22'd0, r_dword}, {22'd0, V_LATCH[i][27:24], V_LATCH[i][7:2]});
                if (V_WR[i])
                    chk(r_wdata == V_EXPWD[i], "R7 write data", r_wdata, V_EXPWD[i]);
            end
        end

        // R6 dword at a non-zero window address still uses lane 0
        access(1, 16'hCF8, 2, 32'h8000_0000, 0, 0);
        access(0, 16'hCFE, 2, 0, 32'hA5A5_0F0F, 0);
        chk(r_be == 4'b1111, "R6 dword enables", {28'd0, r_be}, 32'h0000_000F);
        chk(r_rdata == 32'hA5A5_0F0F, "R6 dword data", r_rdata, 32'hA5A5_0F0F);

        // R9 held request under a 3-cycle ready delay
        access(0, 16'hCFC, 2, 0, 32'h0BAD_F00D, 3);
        chk(r_cycles == 5, "R9 latency with backpressure", r_cycles, 5);
        chk(r_rdata == 32'h0BAD_F00D, "R9 data after backpressure", r_rdata, 32'h0BAD_F00D);
        // R9 local completion in one cycle
        access(0, 16'hCF8, 2, 0, 0, 0);
        chk(r_cycles == 1, "R9 local latency", r_cycles, 1);
        // R5 word at odd address ignores bit 0 (lane 2)
        access(0, 16'hCFF, 1, 0, 32'h4433_2211, 0);
        chk(r_be == 4'b1100, "R5 odd word enables", {28'd0, r_be}, 32'h0000_000C);
        chk(r_rdata == 32'h0000_4433, "R5 odd word data", r_rdata, 32'h0000_4433);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule